// File: doc/BRIEF.md
# Multichannel PWM with Two-Stage Clock Division

This block generates a bank of pulse-width-modulated outputs, controlled through a small register interface. Channels come in pairs. Each pair shares one clock setting: a choice between an oscillator tick and the bus clock, followed by a divider that divides by a power of two. Each channel then divides that shared tick again with its own linear prescaler. The result drives a 16-bit counter that sets the period and the duty cycle.

A channel runs only while both its enable bit and its clock-gate bit are set. Its output has a programmable active level. A new period or active count written while a channel runs is held back until the current period ends, so every cycle of the waveform is complete. Clock division is modelled with clock-enable pulses inside the single bus clock domain. The oscillator is an input that pulses once per oscillator cycle.

There are no streaming paths in this block. Every pin is a plain control or data pin: registers are written on a clock edge, read back combinationally, and the outputs are levels.

Top module: `pwm_bank`

## Requirements
- R1: After reset every register reads 0 and every output sits at its inactive level, which is 1 because the active-state bit resets to 0.
- R2: Registers read back their last written value, masked to their defined bits:
  - pair clock register at 0x20 + 4*(ch>>1): bit 7 and bits 3:0;
  - gate register 0x40 and enable register 0x80: bit n for channel n;
  - channel control register at 0x100 + 0x20*ch: bits 8:0;
  - channel period register at 0x104 + 0x20*ch: all 32 bits.
  Any other address reads 0 and ignores writes.
- R3: A channel runs only when its enable bit and its gate bit are both 1. Otherwise its counter is held at zero and its output shows the inactive level.
- R4: The period register holds two fields. Bits 31:16 hold P, and the waveform repeats every P+1 counter ticks. Bits 15:0 hold A, and the output is active while the counter is below A. The counter starts at 0 in the first cycle after the channel starts running.
- R5: Control bit 8 selects the active level. When it is 1 the active level is high; when it is 0 the active level is low. The inactive level is always the opposite.
- R6: A = 0 gives a constant inactive output. A >= P+1 gives a constant active output.
- R7: The counter tick rate is built in three steps:
  - the source is selected by pair bit 7: 0 takes oscillator pulses, 1 takes every bus clock cycle;
  - the source is divided by 2^d, where d is taken from pair bits 3:0 and values above 8 act as 8;
  - the result is divided by K+1, where K is taken from control bits 7:0.
- R8: Channels 2k and 2k+1 both take their source and divider from the same pair register.
- R9: A period register write made while the channel runs takes effect when the counter wraps at the end of the current period. While the channel is stopped, the latest written value is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, also the fastest counting source |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle pulse per oscillator period |
| bus_addr | input | 12 | Register byte address |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pwm_out | output | NUM_CH | One waveform output per channel |

## Verification
The embedded assertions check the following on every cycle:
- the counter never passes the period that is loaded;
- the counter moves only on a prescaled tick;
- a stopped channel sits at count zero;
- the loaded period and active count stay frozen until the counter wraps;
- the power-of-two divider never produces back-to-back ticks when its divide value is nonzero.

Some behaviour only the bench scenarios can show: the exact duty and period for each mix of source, divider and prescaler; the polarity levels; the boundary timing of a period change; the read-back masks; and the fact that two channels of a pair share one clock register.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int ADDR_W    = 12;
  localparam int DATA_W    = 32;
  localparam int CNT_W     = 16;
  localparam int PSC_W     = 8;
  localparam int DIV_W     = 4;
  localparam int DIV_MAX   = 8;
  localparam int CH_STRIDE = 32;

  localparam logic [ADDR_W-1:0] PAIR_BASE = 12'h020;
  localparam logic [ADDR_W-1:0] GATE_ADDR = 12'h040;
  localparam logic [ADDR_W-1:0] EN_ADDR   = 12'h080;
  localparam logic [ADDR_W-1:0] CH_BASE   = 12'h100;
  localparam logic [ADDR_W-1:0] PER_OFS   = 12'h004;

  typedef struct packed {
    logic             src_bus;
    logic [DIV_W-1:0] div;
  } pair_cfg_t;

  typedef struct packed {
    logic             pol;
    logic [PSC_W-1:0] psc;
    logic [CNT_W-1:0] per;
    logic [CNT_W-1:0] act;
  } chan_cfg_t;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int NUM_PAIR = NUM_CH / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output pair_cfg_t         pair_cfg [NUM_PAIR],
  output chan_cfg_t         chan_cfg [NUM_CH],
  output logic [NUM_CH-1:0] gate,
  output logic [NUM_CH-1:0] en
);
  pair_cfg_t         pair_q [NUM_PAIR];
  logic [8:0]        ctl_q  [NUM_CH];
  logic [DATA_W-1:0] per_q  [NUM_CH];
  logic [NUM_CH-1:0] gate_q, en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= '0;
      en_q   <= '0;
    end else if (we) begin
      if (addr == GATE_ADDR) gate_q <= wdata[NUM_CH-1:0];
      if (addr == EN_ADDR)   en_q   <= wdata[NUM_CH-1:0];
    end
  end

  for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
    localparam logic [ADDR_W-1:0] PA = PAIR_BASE + ADDR_W'(4 * p);
    always_ff @(posedge clk) begin
      if (rst) pair_q[p] <= '0;
      else if (we && addr == PA) pair_q[p] <= '{src_bus: wdata[7], div: wdata[DIV_W-1:0]};
    end
    assign pair_cfg[p] = pair_q[p];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    localparam logic [ADDR_W-1:0] CA = CH_BASE + ADDR_W'(CH_STRIDE * c);
    always_ff @(posedge clk) begin
      if (rst) begin
        ctl_q[c] <= '0;
        per_q[c] <= '0;
      end else if (we) begin
        if (addr == CA)           ctl_q[c] <= wdata[8:0];
        if (addr == CA + PER_OFS) per_q[c] <= wdata;
      end
    end
    assign chan_cfg[c] = '{pol: ctl_q[c][8], psc: ctl_q[c][PSC_W-1:0],
                           per: per_q[c][DATA_W-1:CNT_W], act: per_q[c][CNT_W-1:0]};
  end

  always_comb begin
    rdata = '0;
    if (addr == GATE_ADDR) rdata = DATA_W'(gate_q);
    if (addr == EN_ADDR)   rdata = DATA_W'(en_q);
    for (int p = 0; p < NUM_PAIR; p++) begin
      if (addr == PAIR_BASE + ADDR_W'(4 * p))
        rdata = {24'd0, pair_q[p].src_bus, 3'd0, pair_q[p].div};
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr == CH_BASE + ADDR_W'(CH_STRIDE * c))           rdata = {23'd0, ctl_q[c]};
      if (addr == CH_BASE + ADDR_W'(CH_STRIDE * c) + PER_OFS) rdata = per_q[c];
    end
  end

  assign gate = gate_q;
  assign en   = en_q;

  AST_GATE_WRITE: assert property (@(posedge clk) disable iff (rst) ($past(we) && $past(addr) == GATE_ADDR) |-> gate == $past(wdata[NUM_CH-1:0])); // R2
endmodule

// File: rtl/pwm_pair_clk.sv
module pwm_pair_clk
  import pwm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      osc_tick,
  input  pair_cfg_t cfg,
  output logic      tick_o
);
  logic               src_tick;
  logic [DIV_MAX-1:0] dcnt_q, mask;

  // divide values above DIV_MAX saturate: the mask simply fills up
  always_comb begin
    mask = '0;
    for (int i = 0; i < DIV_MAX; i++) begin
      if (i < int'(cfg.div)) mask[i] = 1'b1;
    end
  end

  assign src_tick = cfg.src_bus ? 1'b1 : osc_tick;

  always_ff @(posedge clk) begin
    if (rst) dcnt_q <= '0;
    else if (src_tick) dcnt_q <= dcnt_q + 1'b1;
  end

  assign tick_o = src_tick && ((dcnt_q & mask) == mask);

  AST_DIV_SPACING: assert property (@(posedge clk) disable iff (rst) (tick_o && cfg.div != '0) |=> (!tick_o || !$stable(cfg))); // R7
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      run,
  input  logic      pair_tick,
  input  chan_cfg_t cfg,
  output logic      pwm_o
);
  logic [PSC_W-1:0] psc_q;
  logic [CNT_W-1:0] cnt_q, per_cur, act_cur;
  logic             psc_wrap, cnt_tick, in_active;

  assign psc_wrap = psc_q >= cfg.psc;
  assign cnt_tick = run && pair_tick && psc_wrap;

  always_ff @(posedge clk) begin
    if (rst || !run) psc_q <= '0;
    else if (pair_tick) psc_q <= psc_wrap ? '0 : psc_q + 1'b1;
  end

  // shadowed period and active count: reload only at a wrap or while stopped
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      per_cur <= '0;
      act_cur <= '0;
    end else if (!run) begin
      cnt_q   <= '0;
      per_cur <= cfg.per;
      act_cur <= cfg.act;
    end else if (cnt_tick) begin
      if (cnt_q >= per_cur) begin
        cnt_q   <= '0;
        per_cur <= cfg.per;
        act_cur <= cfg.act;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign in_active = run && (cnt_q < act_cur);
  assign pwm_o     = in_active ? cfg.pol : ~cfg.pol;

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst) !$past(run) |-> cnt_q == '0); // R3
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst) (run && $past(run)) |-> cnt_q <= per_cur); // R4
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst) ($past(run) && run && $past(cnt_tick) && $past(cnt_q) >= $past(per_cur)) |-> cnt_q == '0); // R4
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst) (run && $past(run) && !$past(cnt_tick)) |-> $stable(cnt_q)); // R7
  AST_MIDPERIOD_FROZEN: assert property (@(posedge clk) disable iff (rst) (run && $past(run) && cnt_q != '0) |-> ($stable(per_cur) && $stable(act_cur))); // R9
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 4,  // even, at most 16 to fit the address map
  localparam int NUM_PAIR = NUM_CH / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              osc_tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  pair_cfg_t           pair_cfg [NUM_PAIR];
  chan_cfg_t           chan_cfg [NUM_CH];
  logic [NUM_CH-1:0]   gate, en;
  logic [NUM_PAIR-1:0] pair_tick;
  logic [NUM_CH-1:0]   wave;

  pwm_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .addr     (bus_addr),
    .we       (bus_we),
    .wdata    (bus_wdata),
    .rdata    (bus_rdata),
    .pair_cfg (pair_cfg),
    .chan_cfg (chan_cfg),
    .gate     (gate),
    .en       (en)
  );

  for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
    pwm_pair_clk u_clk (
      .clk      (clk),
      .rst      (rst),
      .osc_tick (osc_tick),
      .cfg      (pair_cfg[p]),
      .tick_o   (pair_tick[p])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    pwm_chan u_chan (
      .clk       (clk),
      .rst       (rst),
      .run       (en[c] & gate[c]),
      .pair_tick (pair_tick[c/2]),
      .cfg       (chan_cfg[c]),
      .pwm_o     (wave[c])
    );
  end

  assign pwm_out = wave;
endmodule

// File: tb/pwm_bank_test.sv
`timescale 1ns/1ps
module pwm_bank_test;
  localparam int NCH = 4;

  typedef struct packed {
    logic [3:0]  ch;
    logic        src;
    logic [3:0]  div;
    logic [7:0]  psc;
    logic [15:0] per;
    logic [15:0] act;
    logic        pol;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{4'd0, 1'b1, 4'd0, 8'd0, 16'd9, 16'd3,  1'b1},  // R4 R7 bus clock, no division
    '{4'd1, 1'b1, 4'd1, 8'd2, 16'd4, 16'd2,  1'b1},  // R8 ch1 uses pair register 0x20
    '{4'd2, 1'b0, 4'd0, 8'd0, 16'd7, 16'd5,  1'b0},  // R5 R7 oscillator, low active
    '{4'd3, 1'b0, 4'd2, 8'd1, 16'd3, 16'd1,  1'b1},  // R7 R8 both stages
    '{4'd0, 1'b1, 4'd0, 8'd3, 16'd5, 16'd0,  1'b1},  // R6 zero active count
    '{4'd1, 1'b1, 4'd0, 8'd0, 16'd4, 16'd12, 1'b1},  // R6 active beyond period
    '{4'd2, 1'b1, 4'd3, 8'd0, 16'd2, 16'd3,  1'b0},  // R6 active equal to length
    '{4'd3, 1'b0, 4'd8, 8'd0, 16'd1, 16'd1,  1'b1}   // R7 largest divider
  };

  logic            clk, rst, osc_tick, bus_we;
  logic [11:0]     bus_addr;
  logic [31:0]     bus_wdata, bus_rdata, rv;
  logic [NCH-1:0]  pwm_out, pol_sh, others;
  int              n_chk, n_err, osc_ph;
  int              ch, tl, np, win, hi, aeff, act_cyc, exp_hi;

  pwm_bank #(.NUM_CH(NCH)) uut (
    .clk(clk), .rst(rst), .osc_tick(osc_tick), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  initial begin
    clk = 1'b0;
    forever #2 clk = ~clk;
  end

  initial begin
    osc_tick = 1'b0;
    osc_ph = 0;
    forever begin
      @(negedge clk);
      osc_ph = (osc_ph == 2) ? 0 : osc_ph + 1;
      osc_tick = (osc_ph == 2);
    end
  end

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wctl(input int c, input logic pol, input logic [7:0] psc);
    wr(12'h100 + 12'(32 * c), {23'd0, pol, psc});
    pol_sh[c] = pol;
  endtask

  task automatic count_high(input int c, input int len, output int h);
    h = 0;
    for (int i = 0; i < len; i++) begin
      if (pwm_out[c]) h++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
  end

  initial begin
    rst = 1'b1; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    n_chk = 0; n_err = 0; pol_sh = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 outputs idle", 32'(pwm_out), 32'hF);
    rd(12'h020, rv); chk("R1 pair0", rv, 0);
    rd(12'h024, rv); chk("R1 pair1", rv, 0);
    rd(12'h040, rv); chk("R1 gate", rv, 0);
    rd(12'h080, rv); chk("R1 enable", rv, 0);
    rd(12'h100, rv); chk("R1 ctrl0", rv, 0);
    rd(12'h164, rv); chk("R1 period3", rv, 0);

    // R2 read-back masks
    wr(12'h024, 32'hFFFF_FFFF); rd(12'h024, rv); chk("R2 pair mask", rv, 32'h8F);
    wr(12'h040, 32'hFFFF_FFFF); rd(12'h040, rv); chk("R2 gate mask", rv, 32'hF);
    wr(12'h080, 32'hFFFF_FFFF); rd(12'h080, rv); chk("R2 enable mask", rv, 32'hF);
    wr(12'h120, 32'hFFFF_FFFF); rd(12'h120, rv); chk("R2 ctrl mask", rv, 32'h1FF);
    pol_sh[1] = 1'b1;
    wr(12'h144, 32'h1234_ABCD); rd(12'h144, rv); chk("R2 period full", rv, 32'h1234_ABCD);
    wr(12'h0C4, 32'hFFFF_FFFF); rd(12'h0C4, rv); chk("R2 undefined addr", rv, 0);
    wr(12'h108, 32'hFFFF_FFFF); rd(12'h108, rv); chk("R2 hole in channel block", rv, 0);
    wr(12'h080, 0); wr(12'h040, 0);

    // table walk: duty over two whole periods after one settling period
    for (int v = 0; v < NV; v++) begin
      ch = int'(VECS[v].ch);
      wr(12'h080, 0); wr(12'h040, 0);
      wr(12'h020 + 12'(4 * (ch / 2)), {24'd0, VECS[v].src, 3'd0, VECS[v].div});
      wctl(ch, VECS[v].pol, VECS[v].psc);
      wr(12'h104 + 12'(32 * ch), {VECS[v].per, VECS[v].act});
      wr(12'h040, 32'(1 << ch));
      wr(12'h080, 32'(1 << ch));
      tl = (VECS[v].src ? 1 : 3) * (1 << int'(VECS[v].div)) * (int'(VECS[v].psc) + 1);
      np = int'(VECS[v].per) + 1;
      win = 2 * np * tl;
      aeff = (int'(VECS[v].act) > np) ? np : int'(VECS[v].act);
      act_cyc = 2 * aeff * tl;
      exp_hi = VECS[v].pol ? act_cyc : win - act_cyc;
      repeat (np * tl) @(negedge clk);
      count_high(ch, win, hi);
      chk($sformatf("R4 R6 R7 R8 vector %0d high cycles", v), 32'(hi), 32'(exp_hi));
      others = ~pol_sh & ~NCH'(1 << ch);
      chk($sformatf("R3 vector %0d idle channels", v), 32'(pwm_out & ~NCH'(1 << ch)), 32'(others));
    end

    // R3 both enable and gate needed
    wr(12'h080, 0); wr(12'h040, 0);
    wr(12'h020, 32'h80);
    wctl(0, 1'b1, 8'd0);
    wr(12'h104, {16'd9, 16'd5});
    wr(12'h080, 1);
    count_high(0, 20, hi); chk("R3 gate clear keeps idle", 32'(hi), 0);
    wr(12'h080, 0); wr(12'h040, 1);
    count_high(0, 20, hi); chk("R3 enable clear keeps idle", 32'(hi), 0);
    wr(12'h080, 1);
    count_high(0, 20, hi); chk("R3 R4 both set runs", 32'(hi), 10);

    // R4 exact phase from start, R9 period change at the wrap
    wr(12'h080, 0);
    wr(12'h104, {16'd9, 16'd3});
    wr(12'h080, 1);
    for (int i = 0; i < 4; i++) begin
      chk($sformatf("R4 start phase %0d", i), 32'(pwm_out[0]), 32'(i < 3));
      @(negedge clk);
    end
    chk("R4 start phase 4", 32'(pwm_out[0]), 0);
    wr(12'h104, {16'd3, 16'd2});
    for (int i = 5; i < 18; i++) begin
      chk($sformatf("R9 boundary step %0d", i), 32'(pwm_out[0]),
          32'((i < 10) ? 0 : (((i - 10) % 4) < 2)));
      @(negedge clk);
    end

    // R5 polarity of the idle level
    wr(12'h080, 0);
    wctl(0, 1'b0, 8'd0); chk("R5 low-active idles high", 32'(pwm_out[0]), 1);
    wctl(0, 1'b1, 8'd0); chk("R5 high-active idles low", 32'(pwm_out[0]), 0);

    report();
  end
endmodule